// File: doc/BRIEF.md
# Fetch Stream Sequence Tracker

This block sits at the front of an in-order pipeline. It decides where fetching goes next, and it labels every line it fetches so that later logic can drop work that a change of control flow has made stale. It keeps two independent counters for this. The first is a stream number, which moves when the execute stage redirects fetch because of a resolved branch, a fault or an interrupt. The second is a prediction number, which moves when the branch predictor in the fetch-decode stage follows a taken branch. The block also keeps a line counter and the current fetch address.

Execute redirects always beat predictor redirects in the same cycle. A predictor redirect is honoured only if it was made under the stream the fetch side expects. Because of this, a prediction made on a path that execute has already abandoned cannot steer fetch. When a line returns, it is kept only if both of its numbers match the current ones. Lines from the path behind a prediction are therefore dropped, and lines that carry the newest stream number survive. Each accepted prediction raises a one-cycle flush pulse for the downstream input buffer. A suspend request from execute stops fetch and parks the address at the wake-up point. A later stream-changing redirect of any other kind restarts fetch.

Top module: `fetch_stream_tracker`

## Requirements
- R1: After reset the stream, prediction and line numbers are 0, fetchAddr equals RESET_ADDR (default 0x100), fetchEn is 1 and flushBuf is 0.
- R2: lineTag is {thread (always 0) in bits 31:24, stream in 23:16, prediction in 15:8, line number in 7:0} for the default SEQ_W of 8. An accepted issue (lineIssue while fetchEn is 1) increments the line number, which wraps from 255 to 0, and it advances fetchAddr by LINE_BYTES (default 16) when no redirect is taken in that cycle.
- R3: exReason codes 2 (unpredicted taken), 3 (predicted but not taken), 4 (wrong target), 5 (suspend) and 6 (interrupt) increment the stream number, with wrap, and load fetchAddr from exTarget on the next cycle.
- R4: exReason codes 0 (no branch), 1 (correctly predicted) and 7 (unused) leave the stream number unchanged and do not redirect.
- R5: predValid with predStream equal to the current stream, while fetchEn is 1 and no stream-changing code is present, increments the prediction number and loads fetchAddr from predTarget.
- R6: A predictor request whose predStream differs from the current stream has no effect on the prediction number or on fetchAddr.
- R7: When a stream-changing exReason and a predictor request occur in the same cycle, only the execute redirect is applied: fetchAddr takes exTarget, the prediction number holds, and no flush pulse follows.
- R8: flushBuf is 1 in exactly the cycle after an accepted predictor redirect, and 0 otherwise.
- R9: lineKeep is 1 exactly when inValid is 1, inStream equals the current stream and inPred equals the current prediction number. It is evaluated on the state before the clock edge.
- R10: Code 5 clears fetchEn. While fetchEn is 0, lineIssue and predictor requests are ignored and codes 0, 1 and 7 keep fetch halted. Codes 2, 3, 4 and 6 set fetchEn back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exReason | input | 3 | Branch outcome code from execute |
| exTarget | input | AW | Redirect or wake-up address from execute |
| predValid | input | 1 | Predictor requests a taken-branch redirect |
| predTarget | input | AW | Predicted target address |
| predStream | input | SEQ_W | Stream number the prediction was made under |
| lineIssue | input | 1 | A line fetch is issued this cycle |
| inValid | input | 1 | A returned line is presented for a keep decision |
| inStream | input | SEQ_W | Stream number carried by the returned line |
| inPred | input | SEQ_W | Prediction number carried by the returned line |
| fetchAddr | output | AW | Address of the next line to fetch |
| fetchEn | output | 1 | Fetch is running (0 while suspended) |
| lineTag | output | 4*SEQ_W | Tag for the line issued at fetchAddr |
| lineKeep | output | 1 | Returned line is kept (1) or discarded (0) |
| flushBuf | output | 1 | One-cycle flush of the downstream input buffer |

## Verification
Some properties are checked by assertions on every cycle. These are the one-step move of the stream number on stream-changing codes and its stability on the other codes, and the stable prediction number when the stream does not match or execute takes priority. The assertions also check that every flush pulse traces back to an accepted prediction, the halt after a suspend, and the single-step line counter. Other behaviour shows only in the bench scenarios. These are the actual addresses loaded on each redirect kind, the keep-or-discard verdicts before and after a prediction, and the wrap of the line counter. They also include the full suspend and resume sequence with the requests that are ignored while fetch is halted.

// File: rtl/fst_pkg.sv
package fst_pkg;

  typedef enum logic [2:0] {
    BR_NONE    = 3'd0,
    BR_CORRECT = 3'd1,
    BR_UNPRED  = 3'd2,
    BR_BAD_DIR = 3'd3,
    BR_BAD_TGT = 3'd4,
    BR_SUSPEND = 3'd5,
    BR_IRQ     = 3'd6
  } brReason_e;

  typedef struct packed {
    logic exRedirect;
    logic predRedirect;
    logic advance;
    logic halt;
  } strobe_t;

  function automatic logic startsStream(input logic [2:0] code);
    return (code == BR_UNPRED) || (code == BR_BAD_DIR) || (code == BR_BAD_TGT) ||
           (code == BR_SUSPEND) || (code == BR_IRQ);
  endfunction

endpackage

// File: rtl/fst_ctrl.sv
module fst_ctrl
  import fst_pkg::*;
#(
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       exReason,
  input  logic             predValid,
  input  logic [SEQ_W-1:0] predStream,
  input  logic [SEQ_W-1:0] curStream,
  input  logic             lineIssue,
  output strobe_t          stb,
  output logic             fetchEn
);

  logic fetching;
  logic exNew;
  logic streamMatch;

  assign exNew       = startsStream(exReason);
  assign streamMatch = (predStream == curStream);

  always_comb begin
    stb              = '0;
    stb.exRedirect   = exNew;
    stb.halt         = exNew && (exReason == BR_SUSPEND);
    stb.predRedirect = !exNew && predValid && fetching && streamMatch;
    stb.advance      = lineIssue && fetching;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetching <= 1'b1;
    end else if (exNew) begin
      fetching <= !stb.halt;
    end
  end

  assign fetchEn = fetching;

endmodule

// File: rtl/fst_dp.sv
module fst_dp
  import fst_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          SEQ_W      = 8,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned RESET_ADDR = 32'h100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          stb,
  input  logic [AW-1:0]    exTarget,
  input  logic [AW-1:0]    predTarget,
  input  logic             inValid,
  input  logic [SEQ_W-1:0] inStream,
  input  logic [SEQ_W-1:0] inPred,
  output logic [SEQ_W-1:0] streamSeq,
  output logic [SEQ_W-1:0] predSeq,
  output logic [SEQ_W-1:0] lineSeq,
  output logic [AW-1:0]    fetchAddr,
  output logic             flushBuf,
  output logic             lineKeep
);

  localparam logic [AW-1:0]    LINE_STEP = AW'(LINE_BYTES);
  localparam logic [AW-1:0]    BOOT_ADDR = AW'(RESET_ADDR);
  localparam logic [SEQ_W-1:0] SEQ_ONE   = SEQ_W'(1);

  logic [SEQ_W-1:0] streamQ, predQ, lineQ;
  logic [AW-1:0]    addrQ;
  logic             flushQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      streamQ <= '0;
      predQ   <= '0;
      lineQ   <= '0;
      addrQ   <= BOOT_ADDR;
      flushQ  <= 1'b0;
    end else begin
      flushQ <= stb.predRedirect;
      if (stb.advance) begin
        lineQ <= lineQ + SEQ_ONE;
      end
      if (stb.exRedirect) begin
        streamQ <= streamQ + SEQ_ONE;
        addrQ   <= exTarget;
      end else if (stb.predRedirect) begin
        predQ <= predQ + SEQ_ONE;
        addrQ <= predTarget;
      end else if (stb.advance) begin
        addrQ <= addrQ + LINE_STEP;
      end
    end
  end

  assign lineKeep  = inValid && (inStream == streamQ) && (inPred == predQ);
  assign streamSeq = streamQ;
  assign predSeq   = predQ;
  assign lineSeq   = lineQ;
  assign fetchAddr = addrQ;
  assign flushBuf  = flushQ;

endmodule

// File: rtl/fetch_stream_tracker.sv
module fetch_stream_tracker
  import fst_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          SEQ_W      = 8,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned RESET_ADDR = 32'h100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         exReason,
  input  logic [AW-1:0]      exTarget,
  input  logic               predValid,
  input  logic [AW-1:0]      predTarget,
  input  logic [SEQ_W-1:0]   predStream,
  input  logic               lineIssue,
  input  logic               inValid,
  input  logic [SEQ_W-1:0]   inStream,
  input  logic [SEQ_W-1:0]   inPred,
  output logic [AW-1:0]      fetchAddr,
  output logic               fetchEn,
  output logic [4*SEQ_W-1:0] lineTag,
  output logic               lineKeep,
  output logic               flushBuf
);

  localparam logic [SEQ_W-1:0] THREAD_ID = '0;

  strobe_t          stb;
  logic [SEQ_W-1:0] streamSeq, predSeq, lineSeq;

  fst_ctrl #(.SEQ_W(SEQ_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .exReason  (exReason),
    .predValid (predValid),
    .predStream(predStream),
    .curStream (streamSeq),
    .lineIssue (lineIssue),
    .stb       (stb),
    .fetchEn   (fetchEn)
  );

  fst_dp #(
    .AW(AW), .SEQ_W(SEQ_W), .LINE_BYTES(LINE_BYTES), .RESET_ADDR(RESET_ADDR)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .exTarget  (exTarget),
    .predTarget(predTarget),
    .inValid   (inValid),
    .inStream  (inStream),
    .inPred    (inPred),
    .streamSeq (streamSeq),
    .predSeq   (predSeq),
    .lineSeq   (lineSeq),
    .fetchAddr (fetchAddr),
    .flushBuf  (flushBuf),
    .lineKeep  (lineKeep)
  );

  assign lineTag = {THREAD_ID, streamSeq, predSeq, lineSeq};

endmodule

// File: rtl/fst_checker.sv
module fst_checker #(
  parameter int AW    = 32,
  parameter int SEQ_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         exReason,
  input logic               predValid,
  input logic [SEQ_W-1:0]   predStream,
  input logic               lineIssue,
  input logic [AW-1:0]      fetchAddr,
  input logic               fetchEn,
  input logic [4*SEQ_W-1:0] lineTag,
  input logic               flushBuf
);

  logic [SEQ_W-1:0] tStream, tPred, tLine;
  logic             exNew;

  assign tStream = lineTag[3*SEQ_W-1:2*SEQ_W];
  assign tPred   = lineTag[2*SEQ_W-1:SEQ_W];
  assign tLine   = lineTag[SEQ_W-1:0];
  assign exNew   = (exReason >= 3'd2) && (exReason <= 3'd6);

  AST_STREAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    exNew |=> tStream == SEQ_W'($past(tStream) + 1'b1)); // R3

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !exNew |=> $stable(tStream)); // R4

  AST_PRED_STALE: assert property (@(posedge clk) disable iff (!rst_n)
    (predValid && predStream != tStream && !exNew) |=> $stable(tPred)); // R6

  AST_EX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (exNew && predValid) |=> ($stable(tPred) && !flushBuf)); // R7

  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flushBuf |-> $past(predValid && fetchEn && !exNew && predStream == tStream)); // R8

  AST_SUSPEND_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (exReason == 3'd5) |=> !fetchEn); // R10

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (lineIssue && fetchEn) |=> tLine == SEQ_W'($past(tLine) + 1'b1)); // R2

  AST_HALT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetchEn && !exNew) |=> ($stable(fetchAddr) && $stable(tLine) && !fetchEn)); // R10

endmodule

bind fetch_stream_tracker fst_checker #(.AW(AW), .SEQ_W(SEQ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .exReason  (exReason),
  .predValid (predValid),
  .predStream(predStream),
  .lineIssue (lineIssue),
  .fetchAddr (fetchAddr),
  .fetchEn   (fetchEn),
  .lineTag   (lineTag),
  .flushBuf  (flushBuf)
);

// File: tb/sim_fetch_stream_tracker.sv
module sim_fetch_stream_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SEQ_W = 8;
  localparam int LB = 16;
  localparam int BOOT = 32'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] exReason = '0;
  logic [AW-1:0] exTarget = '0, predTarget = '0;
  logic predValid = 1'b0, lineIssue = 1'b0, inValid = 1'b0;
  logic [SEQ_W-1:0] predStream = '0, inStream = '0, inPred = '0;
  logic [AW-1:0] fetchAddr;
  logic fetchEn, lineKeep, flushBuf;
  logic [4*SEQ_W-1:0] lineTag;

  int nCmp = 0, nBad = 0;
  logic [7:0] mStream = 0, mPred = 0, mLine = 0;
  logic [31:0] mAddr = BOOT;
  logic mFetch = 1'b1, mFlush = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_stream_tracker #(.AW(AW), .SEQ_W(SEQ_W), .LINE_BYTES(LB), .RESET_ADDR(BOOT)) u0 (
    .clk(clk), .rst_n(rst_n), .exReason(exReason), .exTarget(exTarget),
    .predValid(predValid), .predTarget(predTarget), .predStream(predStream),
    .lineIssue(lineIssue), .inValid(inValid), .inStream(inStream), .inPred(inPred),
    .fetchAddr(fetchAddr), .fetchEn(fetchEn), .lineTag(lineTag),
    .lineKeep(lineKeep), .flushBuf(flushBuf)
  );

  function automatic logic newStream(input logic [2:0] c);
    return (c >= 3'd2) && (c <= 3'd6);
  endfunction

  function automatic logic expKeep(input logic v, input logic [7:0] s, input logic [7:0] p);
    return v && (s == mStream) && (p == mPred);
  endfunction

  task automatic chk(input string lbl, input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", lbl, act, exp);
    end
  endtask

  task automatic checkRegs(input string lbl);
    chk({lbl, " addr"}, 64'(fetchAddr), 64'(mAddr));
    chk({lbl, " fetchEn"}, 64'(fetchEn), 64'(mFetch));
    chk({lbl, " tag"}, 64'(lineTag), 64'({8'd0, mStream, mPred, mLine}));
    chk({lbl, " flush R8"}, 64'(flushBuf), 64'(mFlush));
  endtask

  task automatic step(input string lbl, input logic [2:0] code, input logic [31:0] eT,
                      input logic pv, input logic [31:0] pT, input logic [7:0] pS,
                      input logic iss, input logic iv, input logic [7:0] iS, input logic [7:0] iP);
    logic exN, predOk, adv;
    @(negedge clk);
    exReason = code; exTarget = eT; predValid = pv; predTarget = pT; predStream = pS;
    lineIssue = iss; inValid = iv; inStream = iS; inPred = iP;
    #1;
    chk({lbl, " keep R9"}, 64'(lineKeep), 64'(expKeep(iv, iS, iP)));
    exN = newStream(code);
    predOk = !exN && pv && mFetch && (pS == mStream);
    adv = iss && mFetch;
    @(posedge clk);
    mLine = mLine + 8'(adv);
    mFlush = predOk;
    if (exN) begin
      mStream = mStream + 8'd1; mAddr = eT; mFetch = (code != 3'd5);
    end else if (predOk) begin
      mPred = mPred + 8'd1; mAddr = pT;
    end else if (adv) begin
      mAddr = mAddr + LB;
    end
    #1;
    checkRegs(lbl);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nBad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    checkRegs("R1 reset");

    step("R2 issue", 0, 0, 0, 0, 0, 1, 0, 0, 0);
    step("R2 issue", 0, 0, 0, 0, 0, 1, 1, 8'd0, 8'd0);
    step("R9 predmiss", 0, 0, 0, 0, 0, 0, 1, 8'd0, 8'd3);
    step("R5 pred", 0, 0, 1, 32'h400, 8'd0, 0, 0, 0, 0);
    step("R8 fall", 0, 0, 0, 0, 0, 0, 1, 8'd0, 8'd0);
    step("R9 newpred", 0, 0, 0, 0, 0, 0, 1, 8'd0, 8'd1);
    step("R6 stale", 0, 0, 1, 32'h800, 8'd5, 1, 0, 0, 0);
    step("R4 correct+R5", 1, 32'h900, 1, 32'h480, 8'd0, 0, 0, 0, 0);
    step("R4 code7", 7, 32'h990, 0, 0, 0, 1, 0, 0, 0);
    step("R7 priority", 3, 32'h1000, 1, 32'h2000, 8'd0, 1, 0, 0, 0);
    step("R9 oldstream", 0, 0, 0, 0, 0, 0, 1, 8'd0, 8'd2);
    step("R3 irq", 6, 32'h3000, 0, 0, 0, 0, 1, 8'd1, 8'd2);
    step("R10 suspend", 5, 32'h3344, 0, 0, 0, 0, 0, 0, 0);
    step("R10 issue ign", 0, 0, 0, 0, 0, 1, 0, 0, 0);
    step("R10 pred ign", 0, 0, 1, 32'h5000, 8'd3, 0, 0, 0, 0);
    step("R10 code1 halt", 1, 32'h6000, 0, 0, 0, 1, 0, 0, 0);
    step("R10 resume R3", 2, 32'h7000, 0, 0, 0, 0, 0, 0, 0);
    step("R3 badtgt", 4, 32'h7100, 0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 260; i++) step("R2 wrap", 0, 0, 0, 0, 0, 1, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] c;
      logic pv;
      logic [7:0] pS, iS, iP;
      c  = ($urandom % 10 < 7) ? 3'd0 : 3'($urandom % 8);
      pv = ($urandom % 10) < 3;
      pS = ($urandom % 2) ? mStream : 8'($urandom);
      iS = ($urandom % 2) ? mStream : mStream - 8'd1;
      iP = ($urandom % 2) ? mPred : 8'($urandom);
      step("RND R3 R5 R9 R10", c, $urandom, pv, $urandom, pS,
           1'($urandom), 1'($urandom), iS, iP);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule